// File: doc/BRIEF.md
# Lockable Test Instruction Decoder

This block sits beside a test access port and turns the current instruction register value into registered select lines. Six boundary-scan operations each have a select of their own. A contiguous run of external user data-register instructions, starting at a parameterised base code, drives a one-hot select vector. A block-select output tells the data path which side to use. A value of 1 routes through the boundary-scan/external side. A value of 0 routes through the internal data-register/bypass side.

Three inclusive code windows are fixed by parameters, and each one is armed by a lock input bit. While a window is armed, every instruction code inside it is refused. Refused codes decode exactly like reserved, unsupported or parameter-disabled codes: no select is raised and block-select falls to 0, which selects bypass.

Each code falls into one of four decode classes: bypass (invalid or refused), boundary-scan, external user, and internal. The class is chosen combinationally from the code and the lock bits. One register stage then turns it into the outputs, so every output follows its instruction one clock edge later.

Top module: `sjd_decoder`

## Requirements
- R1: While `trst_n` is low, all selects and `blk_sel` are 0. The clear is asynchronous and also holds on every clock edge seen during reset.
- R2: An enabled boundary-scan code raises only its own select. The codes are fixed: 0 is extest, 1 is sample, 2 is intest, 3 is runbist, 4 is clamp and 5 is highz.
- R3: `blk_sel` is 1 for extest, sample, intest, runbist and any valid external user code. It is 0 for clamp, highz, internal codes and every refused or invalid code.
- R4: Code `USER_BASE+k`, for k from 0 to `NUM_EXT-1`, sets `ext_sel[k]` alone and sets `blk_sel`. The range test is an unsigned compare on both ends, so no other code can alias into it.
- R5: All other codes give all selects 0 and `blk_sel` 0. This covers the internal codes `INT_LO..INT_HI` (default 'h008 to 'h00F), codes 6 and 7, every code at or above `USER_BASE+NUM_EXT`, and the all-ones code.
- R6: When `win_lock[i]` is 1, every code from `WINi_LO` to `WINi_HI`, both ends included, decodes as in R5. When the bit is 0, the window has no effect. Windows apply to boundary-scan codes and user codes alike.
- R7: A boundary-scan operation whose bit in `BS_ENABLE` is 0 decodes as in R5. Bit i of `BS_ENABLE` belongs to code i. With `EXT_ENABLE` at 0, every user code decodes as in R5.
- R8: Taken together, the six boundary-scan selects and `ext_sel` are one-hot or all zero.
- R9: Outputs change only at a rising clock edge. They reflect the code and lock bits present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| trst_n | input | 1 | Active-low asynchronous test reset |
| ir_value | input | IR_W | Current instruction code |
| win_lock | input | 3 | Arms window i when bit i is 1 |
| sel_extest | output | 1 | Extest select (code 0) |
| sel_sample | output | 1 | Sample/preload select (code 1) |
| sel_intest | output | 1 | Intest select (code 2) |
| sel_runbist | output | 1 | Runbist select (code 3) |
| sel_clamp | output | 1 | Clamp select (code 4) |
| sel_highz | output | 1 | Highz select (code 5) |
| ext_sel | output | NUM_EXT | One-hot external user register select |
| blk_sel | output | 1 | 1: boundary-scan/external path, 0: internal/bypass path |

## Verification
Every decoded result is due one rising edge after its code and lock bits are applied, because the decode has a single register stage. The bench drives inputs on the falling edge and compares at the next falling edge, which lies half a period after the capturing edge. For one code, it also samples just after driving the inputs and before that edge, to confirm the outputs still show the earlier instruction. The reset clear is asynchronous, so it is checked one time step after `trst_n` falls, with no clock edge in between.

// File: rtl/sjd_pkg.sv
package sjd_pkg;

    typedef enum logic [1:0] {
        CLS_BYPASS   = 2'd0,
        CLS_BSCAN    = 2'd1,
        CLS_EXTUSER  = 2'd2,
        CLS_INTERNAL = 2'd3
    } instr_class_e;

    localparam int BS_COUNT = 6;
    localparam int BS_IDX_W = 3;
    localparam int NUM_WIN  = 3;

    // code value equals the op index
    localparam int OP_EXTEST  = 0;
    localparam int OP_SAMPLE  = 1;
    localparam int OP_INTEST  = 2;
    localparam int OP_RUNBIST = 3;
    localparam int OP_CLAMP   = 4;
    localparam int OP_HIGHZ   = 5;

    // ops that route through the boundary-scan side
    localparam logic [BS_COUNT-1:0] BS_ROUTE_MASK = 6'b001111;

endpackage

// File: rtl/sjd_window.sv
module sjd_window #(
    parameter int IR_W = 10,
    parameter int LO   = 0,
    parameter int HI   = 0
) (
    input  logic [IR_W-1:0] ir,
    input  logic            lock,
    output logic            blocked
);
    localparam logic [31:0] LO_U = 32'(LO);
    localparam logic [31:0] HI_U = 32'(HI);

    logic [31:0] ir_u;

    always_comb begin
        ir_u    = 32'(ir);
        blocked = lock && (ir_u >= LO_U) && (ir_u <= HI_U);
    end
endmodule

// File: rtl/sjd_classify.sv
module sjd_classify
    import sjd_pkg::*;
#(
    parameter int                  IR_W       = 10,
    parameter int                  USER_BASE  = 'h10,
    parameter int                  NUM_EXT    = 8,
    parameter int                  EXT_IDX_W  = 3,
    parameter logic [BS_COUNT-1:0] BS_ENABLE  = '1,
    parameter bit                  EXT_ENABLE = 1'b1,
    parameter int                  INT_LO     = 'h008,
    parameter int                  INT_HI     = 'h00F
) (
    input  logic [IR_W-1:0]      ir,
    output instr_class_e         cls,
    output logic [BS_IDX_W-1:0]  bs_idx,
    output logic [EXT_IDX_W-1:0] ext_idx
);
    localparam logic [31:0] BASE_U   = 32'(USER_BASE);
    localparam logic [31:0] END_U    = 32'(USER_BASE) + 32'(NUM_EXT);
    localparam logic [31:0] INT_LO_U = 32'(INT_LO);
    localparam logic [31:0] INT_HI_U = 32'(INT_HI);

    logic [31:0] ir_u;
    logic        hit_bs;
    logic        hit_ext;
    logic        hit_int;

    always_comb begin
        ir_u    = 32'(ir);
        hit_bs  = 1'b0;
        bs_idx  = '0;
        for (int i = 0; i < BS_COUNT; i++) begin
            if (BS_ENABLE[i] && (ir_u == 32'(i))) begin
                hit_bs = 1'b1;
                bs_idx = BS_IDX_W'(i);
            end
        end
        // two-sided unsigned compare; no wrapping subtraction in the test
        hit_ext = EXT_ENABLE && (ir_u >= BASE_U) && (ir_u < END_U);
        ext_idx = hit_ext ? EXT_IDX_W'(ir_u - BASE_U) : '0;
        hit_int = (ir_u >= INT_LO_U) && (ir_u <= INT_HI_U);

        if (hit_bs)       cls = CLS_BSCAN;
        else if (hit_ext) cls = CLS_EXTUSER;
        else if (hit_int) cls = CLS_INTERNAL;
        else              cls = CLS_BYPASS;
    end
endmodule

// File: rtl/sjd_outreg.sv
module sjd_outreg
    import sjd_pkg::*;
#(
    parameter int NUM_EXT   = 8,
    parameter int EXT_IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 trst_n,
    input  instr_class_e         cls,
    input  logic [BS_IDX_W-1:0]  bs_idx,
    input  logic [EXT_IDX_W-1:0] ext_idx,
    output logic [BS_COUNT-1:0]  bs_q,
    output logic [NUM_EXT-1:0]   ext_q,
    output logic                 blk_q
);
    logic [BS_COUNT-1:0] bs_d;
    logic [NUM_EXT-1:0]  ext_d;
    logic                blk_d;

    always_comb begin
        bs_d  = '0;
        ext_d = '0;
        blk_d = 1'b0;
        unique case (cls)
            CLS_BSCAN: begin
                bs_d[bs_idx] = 1'b1;
                blk_d        = BS_ROUTE_MASK[bs_idx];
            end
            CLS_EXTUSER: begin
                ext_d[ext_idx] = 1'b1;
                blk_d          = 1'b1;
            end
            CLS_INTERNAL: blk_d = 1'b0;
            CLS_BYPASS:   blk_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            bs_q  <= '0;
            ext_q <= '0;
            blk_q <= 1'b0;
        end else begin
            bs_q  <= bs_d;
            ext_q <= ext_d;
            blk_q <= blk_d;
        end
    end
endmodule

// File: rtl/sjd_decoder.sv
module sjd_decoder
    import sjd_pkg::*;
#(
    parameter int                  IR_W       = 10,
    parameter int                  USER_BASE  = 'h10,
    parameter int                  NUM_EXT    = 8,
    parameter logic [BS_COUNT-1:0] BS_ENABLE  = '1,
    parameter bit                  EXT_ENABLE = 1'b1,
    parameter int                  INT_LO     = 'h008,
    parameter int                  INT_HI     = 'h00F,
    parameter int                  WIN0_LO    = 'h010,
    parameter int                  WIN0_HI    = 'h011,
    parameter int                  WIN1_LO    = 'h014,
    parameter int                  WIN1_HI    = 'h016,
    parameter int                  WIN2_LO    = 'h002,
    parameter int                  WIN2_HI    = 'h003
) (
    input  logic                 clk,
    input  logic                 trst_n,
    input  logic [IR_W-1:0]      ir_value,
    input  logic [NUM_WIN-1:0]   win_lock,
    output logic                 sel_extest,
    output logic                 sel_sample,
    output logic                 sel_intest,
    output logic                 sel_runbist,
    output logic                 sel_clamp,
    output logic                 sel_highz,
    output logic [NUM_EXT-1:0]   ext_sel,
    output logic                 blk_sel
);
    localparam int EXT_IDX_W = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1;
    localparam int WIN_LO [NUM_WIN] = '{WIN0_LO, WIN1_LO, WIN2_LO};
    localparam int WIN_HI [NUM_WIN] = '{WIN0_HI, WIN1_HI, WIN2_HI};

    logic [NUM_WIN-1:0]   win_hit;
    logic                 refused;
    instr_class_e         raw_cls;
    instr_class_e         eff_cls;
    logic [BS_IDX_W-1:0]  bs_idx;
    logic [EXT_IDX_W-1:0] ext_idx;
    logic [BS_COUNT-1:0]  bs_q;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        sjd_window #(
            .IR_W (IR_W),
            .LO   (WIN_LO[g]),
            .HI   (WIN_HI[g])
        ) u_win (
            .ir      (ir_value),
            .lock    (win_lock[g]),
            .blocked (win_hit[g])
        );
    end

    sjd_classify #(
        .IR_W       (IR_W),
        .USER_BASE  (USER_BASE),
        .NUM_EXT    (NUM_EXT),
        .EXT_IDX_W  (EXT_IDX_W),
        .BS_ENABLE  (BS_ENABLE),
        .EXT_ENABLE (EXT_ENABLE),
        .INT_LO     (INT_LO),
        .INT_HI     (INT_HI)
    ) u_cls (
        .ir      (ir_value),
        .cls     (raw_cls),
        .bs_idx  (bs_idx),
        .ext_idx (ext_idx)
    );

    always_comb begin
        refused = |win_hit;
        eff_cls = refused ? CLS_BYPASS : raw_cls;
    end

    sjd_outreg #(
        .NUM_EXT   (NUM_EXT),
        .EXT_IDX_W (EXT_IDX_W)
    ) u_out (
        .clk     (clk),
        .trst_n  (trst_n),
        .cls     (eff_cls),
        .bs_idx  (bs_idx),
        .ext_idx (ext_idx),
        .bs_q    (bs_q),
        .ext_q   (ext_sel),
        .blk_q   (blk_sel)
    );

    always_comb begin
        sel_extest  = bs_q[OP_EXTEST];
        sel_sample  = bs_q[OP_SAMPLE];
        sel_intest  = bs_q[OP_INTEST];
        sel_runbist = bs_q[OP_RUNBIST];
        sel_clamp   = bs_q[OP_CLAMP];
        sel_highz   = bs_q[OP_HIGHZ];
    end
endmodule

// File: rtl/sjd_decoder_chk.sv
module sjd_decoder_chk #(
    parameter int IR_W      = 10,
    parameter int USER_BASE = 'h10,
    parameter int NUM_EXT   = 8,
    parameter int WIN0_LO   = 'h010,
    parameter int WIN0_HI   = 'h011,
    parameter int WIN1_LO   = 'h014,
    parameter int WIN1_HI   = 'h016,
    parameter int WIN2_LO   = 'h002,
    parameter int WIN2_HI   = 'h003
) (
    input logic               clk,
    input logic               trst_n,
    input logic [IR_W-1:0]    ir_value,
    input logic [2:0]         win_lock,
    input logic               sel_extest,
    input logic               sel_sample,
    input logic               sel_intest,
    input logic               sel_runbist,
    input logic               sel_clamp,
    input logic               sel_highz,
    input logic [NUM_EXT-1:0] ext_sel,
    input logic               blk_sel
);
    localparam logic [31:0] BASE_U = 32'(USER_BASE);
    localparam logic [31:0] END_U  = 32'(USER_BASE) + 32'(NUM_EXT);

    logic [31:0] ir_u;
    logic        in_lock;
    logic        in_user;
    logic [5:0]  bs_all;
    logic        live;

    always_comb begin
        ir_u    = 32'(ir_value);
        in_lock = (win_lock[0] && ir_u >= 32'(WIN0_LO) && ir_u <= 32'(WIN0_HI)) ||
                  (win_lock[1] && ir_u >= 32'(WIN1_LO) && ir_u <= 32'(WIN1_HI)) ||
                  (win_lock[2] && ir_u >= 32'(WIN2_LO) && ir_u <= 32'(WIN2_HI));
        in_user = (ir_u >= BASE_U) && (ir_u < END_U);
        bs_all  = {sel_highz, sel_clamp, sel_runbist, sel_intest, sel_sample, sel_extest};
    end

    // set once a decode has been captured outside reset
    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) live <= 1'b0;
        else         live <= 1'b1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !trst_n |=> (bs_all == '0 && ext_sel == '0 && !blk_sel));

    a_r3_route_matches_sel: assert property (@(posedge clk) disable iff (!trst_n)
        blk_sel == ((|ext_sel) || sel_extest || sel_sample || sel_intest || sel_runbist));

    a_r8_onehot_selects: assert property (@(posedge clk) disable iff (!trst_n)
        $onehot0({bs_all, ext_sel}));

    a_r4_user_decode: assert property (@(posedge clk) disable iff (!trst_n)
        live && $past(in_user) && !$past(in_lock)
        |-> (ext_sel == (NUM_EXT'(1) << ($past(ir_u) - BASE_U)) && blk_sel));

    a_r6_window_refuses: assert property (@(posedge clk) disable iff (!trst_n)
        live && $past(in_lock) |-> (bs_all == '0 && ext_sel == '0 && !blk_sel));

    a_r5_above_range: assert property (@(posedge clk) disable iff (!trst_n)
        live && $past(ir_u >= END_U) && $past(ir_u >= 32'd6)
        |-> (bs_all == '0 && ext_sel == '0 && !blk_sel));
endmodule

bind sjd_decoder sjd_decoder_chk #(
    .IR_W      (IR_W),
    .USER_BASE (USER_BASE),
    .NUM_EXT   (NUM_EXT),
    .WIN0_LO   (WIN0_LO),
    .WIN0_HI   (WIN0_HI),
    .WIN1_LO   (WIN1_LO),
    .WIN1_HI   (WIN1_HI),
    .WIN2_LO   (WIN2_LO),
    .WIN2_HI   (WIN2_HI)
) u_sjd_chk (
    .clk         (clk),
    .trst_n      (trst_n),
    .ir_value    (ir_value),
    .win_lock    (win_lock),
    .sel_extest  (sel_extest),
    .sel_sample  (sel_sample),
    .sel_intest  (sel_intest),
    .sel_runbist (sel_runbist),
    .sel_clamp   (sel_clamp),
    .sel_highz   (sel_highz),
    .ext_sel     (ext_sel),
    .blk_sel     (blk_sel)
);

// File: tb/sjd_decoder_test.sv
module sjd_decoder_test;
    localparam int        CLK_PERIOD = 10;
    localparam int        IR_W       = 10;
    localparam int        BASE       = 'h10;
    localparam int        NEXT       = 8;
    localparam logic [5:0] BSEN      = 6'b110111;  // runbist disabled
    localparam int        W0L = 'h010, W0H = 'h011;
    localparam int        W1L = 'h014, W1H = 'h016;
    localparam int        W2L = 'h002, W2H = 'h003;

    logic            clk = 1'b0;
    logic            trst_n;
    logic [IR_W-1:0] ir_value;
    logic [2:0]      win_lock;
    logic            sel_extest, sel_sample, sel_intest, sel_runbist, sel_clamp, sel_highz;
    logic [NEXT-1:0] ext_sel;
    logic            blk_sel;
    logic [14:0]     obs;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sjd_decoder #(
        .IR_W      (IR_W),
        .USER_BASE (BASE),
        .NUM_EXT   (NEXT),
        .BS_ENABLE (BSEN)
    ) uut (
        .clk         (clk),
        .trst_n      (trst_n),
        .ir_value    (ir_value),
        .win_lock    (win_lock),
        .sel_extest  (sel_extest),
        .sel_sample  (sel_sample),
        .sel_intest  (sel_intest),
        .sel_runbist (sel_runbist),
        .sel_clamp   (sel_clamp),
        .sel_highz   (sel_highz),
        .ext_sel     (ext_sel),
        .blk_sel     (blk_sel)
    );

    assign obs = {blk_sel, sel_highz, sel_clamp, sel_runbist, sel_intest,
                  sel_sample, sel_extest, ext_sel};

    // packing: [14] blk_sel, [13:8] op selects by code, [7:0] ext_sel
    function automatic logic [14:0] model(int code, int lk);
        logic [14:0] r = '0;
        bit locked = 0;
        if (lk[0] && code >= W0L && code <= W0H) locked = 1;
        if (lk[1] && code >= W1L && code <= W1H) locked = 1;
        if (lk[2] && code >= W2L && code <= W2H) locked = 1;
        if (locked) return r;
        if (code < 6 && BSEN[code]) begin
            r[8+code] = 1'b1;
            r[14]     = (code < 4);
        end else if (code >= BASE && code < BASE + NEXT) begin
            r[code-BASE] = 1'b1;
            r[14]        = 1'b1;
        end
        return r;
    endfunction

    function automatic string tag_of(int code, int lk);
        bit locked = (lk[0] && code >= W0L && code <= W0H) ||
                     (lk[1] && code >= W1L && code <= W1H) ||
                     (lk[2] && code >= W2L && code <= W2H);
        if (locked)                                 return "R6";
        if (code < 6 && !BSEN[code])                return "R7";
        if (code < 6)                               return "R2/R3";
        if (code >= BASE && code < BASE + NEXT)     return "R4";
        return "R5";
    endfunction

    task automatic check(string tag, int code, logic [14:0] got, logic [14:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s code=%0h lock=%0d got=%h exp=%h", tag, code, win_lock, got, exp);
        end
    endtask

    task automatic check_onehot(int code);
        total++;
        if (!$onehot0(obs[13:0])) begin
            bad++;
            $display("FAIL R8 code=%0h got=%h exp=onehot0", code, obs[13:0]);
        end
    endtask

    initial begin
        trst_n   = 1'b0;
        ir_value = '0;
        win_lock = '0;
        repeat (2) @(negedge clk);
        ir_value = IR_W'(BASE);
        @(negedge clk);
        check("R1", BASE, obs, 15'h0);               // R1 held reset ignores code
        trst_n   = 1'b1;
        ir_value = '1;
        @(negedge clk);
        check("R5", 'h3FF, obs, 15'h0);              // R5 all-ones

        // R9: nothing moves before the capturing edge
        ir_value = IR_W'(BASE + 3);
        #1;
        check("R9", BASE + 3, obs, 15'h0);
        @(negedge clk);
        check("R9", BASE + 3, obs, model(BASE + 3, 0));

        // sweep: every code under every lock pattern
        for (int lk = 0; lk < 8; lk++) begin
            win_lock = 3'(lk);
            for (int code = 0; code < (1 << IR_W); code++) begin
                ir_value = IR_W'(code);
                @(negedge clk);
                check(tag_of(code, lk), code, obs, model(code, lk));
                check_onehot(code);
            end
        end

        // R1: asynchronous clear mid-run
        win_lock = '0;
        ir_value = IR_W'(BASE);
        @(negedge clk);
        check("R4", BASE, obs, model(BASE, 0));
        #2 trst_n = 1'b0;
        #1;
        check("R1", BASE, obs, 15'h0);
        @(negedge clk);
        trst_n = 1'b1;
        @(negedge clk);
        check("R4", BASE, obs, model(BASE, 0));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule